// File: doc/BRIEF.md
# Cross-Domain Debug Control Register

This block is a small control register for a debug unit. A host writes and reads it through the scan clock (`tck`), and it drives control signals into a core clock (`clk`) that has no fixed relation to `tck`. It carries three controls. The first is a debug request, which is merged with an external request pin. The second is a disable that blocks breakpoint and watchpoint match pulses before they reach the core. The third is an interrupt-disable, which together with the debug acknowledge sets the interrupt enable output.

The internal request is staged in a holding flop in the scan domain. That flop is loaded only on `tck` edges where the TAP reports Run-Test-Idle. A host can therefore arm the request in several cores while they keep running, and then release all of them together by moving every TAP into Run-Test-Idle. The disable bit crosses into the core domain through two flops and comes back through two more. The host reads the bit back and polls until it sees the new value, which shows that the change has taken effect in both domains.

Top module: `dbg_ctrl_xdom`

## Requirements
- R1: While `arst_n` is low, all state is 0. Right after reset, `rd_data` reads 0, `dbg_req_out` equals `ext_dbg_req`, `irq_en` equals the inverse of `dbg_ack`, and match inputs pass through unchanged.
- R2: On a `tck` edge with `wr_en` high, the register takes `wr_data`. From the next edge on, `rd_data` returns every written bit except bit 5.
- R3: The request holding flop loads register bit 1 only on `tck` edges where `tap_idle` is 1. On all other edges it keeps its value.
- R4: The holding flop's value reaches the core through two `clk` flops. It is then ORed into `dbg_req_out`.
- R5: `ext_dbg_req` drives `dbg_req_out` combinationally, whatever the TAP state or the register contents.
- R6: Register bit 5 crosses into the core through two `clk` flops. While the crossed value is 1, `bkpt_match_out` and `wpt_match_out` are 0. While it is 0, they follow their inputs.
- R7: `rd_data[5]` reports the core-side disable value after it has passed through two more `tck` flops. It does not report the written bit directly.
- R8: `irq_en` is 1 only when `dbg_ack` is 0 and register bit 2 (interrupt disable) is 0.
- R9: If bit 1 is written or cleared while `tap_idle` is 0, `dbg_req_out` keeps its old value until a `tck` edge occurs with `tap_idle` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan/test clock |
| clk | input | 1 | Core clock, asynchronous to tck |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| tap_idle | input | 1 | TAP is in Run-Test-Idle (tck domain) |
| wr_en | input | 1 | Register write strobe (tck domain) |
| wr_data | input | W | Register write data |
| rd_data | output | W | Register read-back; bit 5 is the round-tripped disable |
| ext_dbg_req | input | 1 | External debug request |
| dbg_ack | input | 1 | Core debug acknowledge |
| bkpt_match_in | input | 1 | Breakpoint comparator result |
| wpt_match_in | input | 1 | Watchpoint comparator result |
| dbg_req_out | output | 1 | Combined debug request to core |
| irq_en | output | 1 | Interrupt enable |
| bkpt_match_out | output | 1 | Gated breakpoint match |
| wpt_match_out | output | 1 | Gated watchpoint match |

## Verification
The bench sets bit 1 while the TAP is away from Run-Test-Idle and confirms the request stays low until an idle edge. A design with a free-running latch would raise the request early and break the simultaneous release across cores. Clearing the bit outside idle is also tested, since a request that dropped early would let a core leave debug before the others. The read-back of bit 5 is polled and compared every cycle with the round-trip latency. A design that echoed the written value would show the bit before the core-side gating is in force, and a design with a missing synchronizer stage would show it one edge early. The interrupt enable is tried under all four combinations of acknowledge and disable, and the external request is toggled with the register both cleared and set.

// File: rtl/dbg_ctrl_xdom.sv
module dbg_ctrl_xdom #(
  parameter int W       = 6,
  parameter int REQ_BIT = 1,
  parameter int IRQ_BIT = 2,
  parameter int DIS_BIT = 5
) (
  input  logic         tck,
  input  logic         clk,
  input  logic         arst_n,
  input  logic         tap_idle,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ext_dbg_req,
  input  logic         dbg_ack,
  input  logic         bkpt_match_in,
  input  logic         wpt_match_in,
  output logic         dbg_req_out,
  output logic         irq_en,
  output logic         bkpt_match_out,
  output logic         wpt_match_out
);

  logic [W-1:0] ctrl_q;
  logic         req_hold;
  logic [1:0]   req_sync;
  logic [1:0]   dis_sync;
  logic [1:0]   ret_sync;

  always_ff @(posedge tck or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q   <= '0;
      req_hold <= 1'b0;
      ret_sync <= '0;
    end else begin
      if (wr_en)    ctrl_q   <= wr_data;
      if (tap_idle) req_hold <= ctrl_q[REQ_BIT];
      ret_sync <= {ret_sync[0], dis_sync[1]};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req_sync <= '0;
      dis_sync <= '0;
    end else begin
      req_sync <= {req_sync[0], req_hold};
      dis_sync <= {dis_sync[0], ctrl_q[DIS_BIT]};
    end
  end

  always_comb begin
    rd_data          = ctrl_q;
    rd_data[DIS_BIT] = ret_sync[1];
  end

  assign dbg_req_out    = req_sync[1] | ext_dbg_req;
  assign irq_en         = ~dbg_ack & ~ctrl_q[IRQ_BIT];
  assign bkpt_match_out = bkpt_match_in & ~dis_sync[1];
  assign wpt_match_out  = wpt_match_in & ~dis_sync[1];

endmodule

module dbg_ctrl_xdom_chk #(
  parameter int W       = 6,
  parameter int DIS_BIT = 5
) (
  input logic         tck,
  input logic         clk,
  input logic         arst_n,
  input logic         tap_idle,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         ext_dbg_req,
  input logic         dbg_ack,
  input logic         dbg_req_out,
  input logic         irq_en,
  input logic         req_hold
);
  localparam logic [W-1:0] RD_MASK = ~(W'(1) << DIS_BIT);

  AST_WRITE_READBACK: assert property (@(posedge tck) disable iff (!arst_n)
    wr_en |=> ((rd_data & RD_MASK) == ($past(wr_data) & RD_MASK))); // R2

  AST_HOLD_OUTSIDE_IDLE: assert property (@(posedge tck) disable iff (!arst_n)
    !tap_idle |=> $stable(req_hold)); // R3

  AST_EXT_REQ_PASS: assert property (@(posedge clk) disable iff (!arst_n)
    ext_dbg_req |-> dbg_req_out); // R5

  AST_ACK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!arst_n)
    dbg_ack |-> !irq_en); // R8
endmodule

bind dbg_ctrl_xdom dbg_ctrl_xdom_chk #(.W(W), .DIS_BIT(DIS_BIT)) u_chk (
  .tck(tck), .clk(clk), .arst_n(arst_n), .tap_idle(tap_idle),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ext_dbg_req(ext_dbg_req), .dbg_ack(dbg_ack),
  .dbg_req_out(dbg_req_out), .irq_en(irq_en), .req_hold(req_hold)
);

// File: tb/dbg_ctrl_xdom_test.sv
module dbg_ctrl_xdom_test;
  localparam int W = 6;

  logic tck = 0, clk = 0, arst_n = 0;
  logic tap_idle = 0, wr_en = 0, ext_dbg_req = 0, dbg_ack = 0;
  logic bkpt_match_in = 0, wpt_match_in = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic dbg_req_out, irq_en, bkpt_match_out, wpt_match_out;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;
  always #33 tck = ~tck;

  dbg_ctrl_xdom uut (
    .tck(tck), .clk(clk), .arst_n(arst_n), .tap_idle(tap_idle),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_dbg_req(ext_dbg_req), .dbg_ack(dbg_ack),
    .bkpt_match_in(bkpt_match_in), .wpt_match_in(wpt_match_in),
    .dbg_req_out(dbg_req_out), .irq_en(irq_en),
    .bkpt_match_out(bkpt_match_out), .wpt_match_out(wpt_match_out)
  );

  // behavioural reference: queues stand for crossing latency
  logic [W-1:0] m_reg;
  bit m_arm, m_req_core, m_dis_core, m_ret;
  bit q_req[$], q_dis[$], q_ret[$];

  always @(posedge tck or negedge arst_n) begin
    if (!arst_n) begin
      m_reg = '0; m_arm = 0; m_ret = 0; q_ret = '{0};
    end else begin
      bit nxt_arm;
      nxt_arm = tap_idle ? m_reg[1] : m_arm;
      q_ret.push_back(m_dis_core);
      m_ret = q_ret.pop_front();
      if (wr_en) m_reg = wr_data;
      m_arm = nxt_arm;
    end
  end

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_req_core = 0; m_dis_core = 0; q_req = '{0}; q_dis = '{0};
    end else begin
      q_req.push_back(m_arm);
      q_dis.push_back(m_reg[5]);
      m_req_core = q_req.pop_front();
      m_dis_core = q_dis.pop_front();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (arst_n) begin
    logic [W-1:0] exp_rd;
    exp_rd = m_reg; exp_rd[5] = m_ret;
    chk("R4 dbg_req_out", dbg_req_out, m_req_core | ext_dbg_req);
    chk("R8 irq_en", irq_en, !dbg_ack && !m_reg[2]);
    chk("R6 bkpt_match_out", bkpt_match_out, bkpt_match_in && !m_dis_core);
    chk("R6 wpt_match_out", wpt_match_out, wpt_match_in && !m_dis_core);
    chk("R2 rd_data", rd_data & 6'h1f, exp_rd & 6'h1f);
    chk("R7 rd_data[5]", rd_data[5], exp_rd[5]);
  end

  task automatic tck_wait(int n);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  task automatic write_reg(logic [W-1:0] d);
    @(negedge tck); wr_en = 1; wr_data = d;
    @(negedge tck); wr_en = 0;
  endtask

  task automatic pulse_idle();
    @(negedge tck); tap_idle = 1;
    @(negedge tck); tap_idle = 0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #105 arst_n = 1;
    #6;
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset dbg_req_out", dbg_req_out, 0);
    chk("R1 reset irq_en", irq_en, 1);
    bkpt_match_in = 1; #1;
    chk("R1 reset bkpt pass", bkpt_match_out, 1);
    bkpt_match_in = 0;

    // arm request outside idle: must not appear
    write_reg(6'b000010);
    tck_wait(6);
    #5 chk("R9 armed request held back", dbg_req_out, 0);
    pulse_idle();
    tck_wait(2);
    #5 chk("R3 request released on idle", dbg_req_out, 1);

    // clear outside idle: request remains
    write_reg(6'b000000);
    tck_wait(5);
    #5 chk("R9 cleared request still held", dbg_req_out, 1);
    pulse_idle();
    tck_wait(2);
    #5 chk("R4 request dropped after idle", dbg_req_out, 0);

    // external request passes regardless
    @(negedge tck); ext_dbg_req = 1; #1;
    chk("R5 ext request direct", dbg_req_out, 1);
    tap_idle = 1; tck_wait(3); tap_idle = 0;
    ext_dbg_req = 0; #1;
    chk("R5 ext request released", dbg_req_out, 0);

    // interrupt enable truth table
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++) begin
        write_reg(d ? 6'b000100 : 6'b000000);
        dbg_ack = a[0]; #1;
        chk("R8 irq_en combination", irq_en, (a == 0 && d == 0));
      end
    dbg_ack = 0;

    // disable round trip with polling
    bkpt_match_in = 1; wpt_match_in = 1;
    write_reg(6'b100000);
    for (int i = 0; i < 20 && rd_data[5] !== 1'b1; i++) @(negedge tck);
    #5 chk("R7 disable read back set", rd_data[5], 1);
    chk("R6 bkpt blocked", bkpt_match_out, 0);
    chk("R6 wpt blocked", wpt_match_out, 0);
    write_reg(6'b000000);
    for (int i = 0; i < 20 && rd_data[5] !== 1'b0; i++) @(negedge tck);
    #5 chk("R7 disable read back clear", rd_data[5], 0);
    chk("R6 bkpt passes", bkpt_match_out, 1);
    bkpt_match_in = 0; wpt_match_in = 0;

    // plain storage pattern
    write_reg(6'b011001);
    #5 chk("R2 pattern read back", rd_data, 6'b011001);
    write_reg(6'b000110);
    #5 chk("R2 second pattern", rd_data, 6'b000110);
    tck_wait(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule